// File: doc/BRIEF.md
# Dual-Descriptor Bidirectional Byte DMA Channel

This block is one DMA channel that moves bytes between system memory and a byte-wide peripheral, in either direction. It holds two buffer descriptors, slot A and slot B. Software arms them in turn. The engine works through one armed slot, then turns to the other one. While the engine runs, software can reload whichever slot is idle. Each descriptor carries a buffer start address, a byte count and a flag that requests a terminal-count strobe to the peripheral once that buffer is finished.

Software reaches the block through one write port. A two-bit select on that port addresses slot A, slot B or the control word. Two read-only outputs show the control state and a diagnostic word. Memory is reached through a request/grant port that moves one byte per grant. The peripheral side has a valid/ready byte handshake for each direction, plus the terminal-count strobe. Three interrupt lines report that slot A is finished, that slot B is finished, and that a memory access failed.

The engine needs two grant-or-handshake steps per byte: one memory access and one peripheral handshake.

Top module: `bidir_byte_dma`

## Requirements
- R1: A descriptor write (select 0 for slot A, select 1 for slot B) splits the 64-bit word into three fields. Bits [31:0] are the start address, bits [43:32] are the byte count and bit 63 is the terminal-count flag. The remaining bits are ignored.
- R2: With direction 0, the engine reads bytes from memory at the start address and each following address, one address higher per byte. It hands each byte to the peripheral in that order.
- R3: With direction 1, the engine accepts bytes from the peripheral and writes them to memory at the start address and each following address, one address higher per byte.
- R4: A control write (select 2) sets the direction from bit 0 and the run enable from bit 1. A 1 in bit 3 arms slot B and a 1 in bit 4 arms slot A; a 0 in either bit changes nothing. A 1 in bit 2 resets the channel: direction, enable and both armed bits become 0, and the engine returns to slot A. The control output shows the direction in bit 0, the enable in bit 1, a constant 0 in bit 2, slot B armed in bit 3 and slot A armed in bit 4. It reads 0 after reset.
- R5: While the enable is 0, the engine makes no memory request and no peripheral handshake, and the remaining count is held. Setting the enable to 1 again resumes the transfer where it stopped.
- R6: The engine starts on slot A after reset. When a slot's last byte is done, the engine clears that slot's armed bit, pulses that slot's interrupt for exactly one cycle and switches to the other slot. If the other slot is armed, the engine starts it.
- R7: When the finished slot's terminal-count flag is 1, the terminal-count output pulses for one cycle, together with that slot's finish interrupt. When the flag is 0, there is no pulse.
- R8: A slot with a byte count of zero finishes without making any memory request.
- R9: When memory answers a request with an error, the engine stops, the enable bit is cleared, the memory-error interrupt pulses for one cycle and no further request is made.
- R10: The diagnostic output shows the current slot in bit 0 (0 = A). Bit 1 is 1 while the engine is enabled and a transfer is in progress. Bits [13:2] hold the bytes still to move, and this count is 0 when the engine is idle.
- R11: A descriptor write to a slot is ignored while that slot is armed and is the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 slot A, 1 slot B, 2 control |
| reg_wdata | input | 64 | Write data |
| ctrl_q | output | 5 | Control state view |
| diag_q | output | LEN_W+2 (14) | Diagnostic view |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (32) | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with grant |
| mem_err | input | 1 | Error response, valid with grant |
| dev_out_valid | output | 1 | Byte offered to peripheral |
| dev_out_data | output | 8 | Byte to peripheral |
| dev_out_ready | input | 1 | Peripheral takes the byte |
| dev_in_valid | input | 1 | Peripheral offers a byte |
| dev_in_data | input | 8 | Byte from peripheral |
| dev_in_ready | output | 1 | Engine takes the byte |
| dev_tc | output | 1 | Terminal-count strobe |
| irq_ctx_a | output | 1 | Slot A finished |
| irq_ctx_b | output | 1 | Slot B finished |
| irq_mem_err | output | 1 | Memory error |

## Verification
The assertions assume that software keeps every buffer inside one 4 KB page. They also assume that memory raises grant only in a cycle with a request, and that an error response comes together with its grant. If these hold, the address the engine presents never leaves the page the buffer started in. The stimulus keeps to these rules: every buffer fits inside its page, and one buffer ends on the last byte of a page. Peripheral-to-memory buffers start on 64-byte boundaries. The bench grants every request in the cycle it is raised, and it returns an error only at one chosen address.

// File: rtl/bbd_pkg.sv
package bbd_pkg;
   // descriptor field layout (software visible)
   localparam int DESC_W      = 64;
   localparam int LEN_LSB     = 32;
   localparam int LEN_FIELD_W = 12;
   localparam int LAST_BIT    = 63;
   localparam int PAGE_LSB    = 12;

   // control word bit positions
   localparam int CB_DIR = 0;
   localparam int CB_EN  = 1;
   localparam int CB_RST = 2;
   localparam int CB_VB  = 3;
   localparam int CB_VA  = 4;

   localparam logic [1:0] SEL_A    = 2'd0;
   localparam logic [1:0] SEL_B    = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MRD,   // memory read pending
      ST_DWR,   // byte offered to peripheral
      ST_DRD,   // waiting for peripheral byte
      ST_MWR    // memory write pending
   } eng_st_t;
endpackage

// File: rtl/bbd_desc_slot.sv
module bbd_desc_slot #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wbase_i,
   input  logic [LEN_W-1:0]  wlen_i,
   input  logic              wlast_i,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic              lock_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              last_o,
   output logic              valid_o
);
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic              last_q;
   logic              valid_q;
   logic              wr_ok;

   assign wr_ok = wr_i && !(lock_i && valid_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         len_q   <= '0;
         last_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (wr_ok) begin
            base_q <= wbase_i;
            len_q  <= wlen_i;
            last_q <= wlast_i;
         end
         if (clr_i)      valid_q <= 1'b0;
         else if (set_i) valid_q <= 1'b1;
      end
   end

   assign base_o  = base_q;
   assign len_o   = len_q;
   assign last_o  = last_q;
   assign valid_o = valid_q;

   // R11: a write to an armed, current slot leaves the descriptor untouched
   p_locked_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && lock_i && valid_q) |=> ($stable(base_q) && $stable(len_q) && $stable(last_q)));

   // R6: the armed bit only drops after a finish or channel reset request
   p_valid_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_q) |-> $past(clr_i));
endmodule

// File: rtl/bbd_engine.sv
module bbd_engine
   import bbd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst_i,
   input  logic              en_i,
   input  logic              dir_i,
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              last_i,
   output logic              cur_o,
   output logic              fin_o,
   output logic              merr_o,
   output logic              busy_o,
   output logic [LEN_W-1:0]  cnt_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic [7:0]        mem_rdata_i,
   input  logic              mem_err_i,
   output logic              dev_out_valid_o,
   output logic [7:0]        dev_out_data_o,
   input  logic              dev_out_ready_i,
   input  logic              dev_in_valid_i,
   input  logic [7:0]        dev_in_data_i,
   output logic              dev_in_ready_o,
   output logic              tc_o,
   output logic              irq_a_o,
   output logic              irq_b_o,
   output logic              irq_m_o
);
   localparam int PAGE_W = ADDR_W - PAGE_LSB;

   eng_st_t           st_q;
   logic              cur_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PAGE_W-1:0] page_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [7:0]        byte_q;
   logic              irq_a_q, irq_b_q, irq_m_q, tc_q;

   logic start, mem_hs, merr, byte_done, fin;

   always_comb begin
      start     = (st_q == ST_IDLE) && en_i && valid_i;
      mem_hs    = en_i && mem_gnt_i && ((st_q == ST_MRD) || (st_q == ST_MWR));
      merr      = mem_hs && mem_err_i;
      byte_done = (en_i && (st_q == ST_DWR) && dev_out_ready_i)
               || (mem_hs && !mem_err_i && (st_q == ST_MWR));
      fin       = (start && (len_i == '0)) || (byte_done && (cnt_q == LEN_W'(1)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cur_q   <= 1'b0;
         addr_q  <= '0;
         page_q  <= '0;
         cnt_q   <= '0;
         byte_q  <= '0;
         irq_a_q <= 1'b0;
         irq_b_q <= 1'b0;
         irq_m_q <= 1'b0;
         tc_q    <= 1'b0;
      end else begin
         irq_a_q <= 1'b0;
         irq_b_q <= 1'b0;
         irq_m_q <= 1'b0;
         tc_q    <= 1'b0;
         if (chan_rst_i) begin
            st_q  <= ST_IDLE;
            cur_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            case (st_q)
               ST_IDLE: if (start) begin
                  addr_q <= base_i;
                  page_q <= base_i[ADDR_W-1:PAGE_LSB];
                  cnt_q  <= len_i;
                  st_q   <= dir_i ? ST_DRD : ST_MRD;
               end
               ST_MRD: if (mem_hs && !mem_err_i) begin
                  byte_q <= mem_rdata_i;
                  st_q   <= ST_DWR;
               end
               ST_DWR: if (byte_done) st_q <= ST_MRD;
               ST_DRD: if (en_i && dev_in_valid_i) begin
                  byte_q <= dev_in_data_i;
                  st_q   <= ST_MWR;
               end
               ST_MWR: if (byte_done) st_q <= ST_DRD;
               default: st_q <= ST_IDLE;
            endcase
            if (byte_done) begin
               addr_q <= addr_q + 1'b1;
               cnt_q  <= cnt_q - 1'b1;
            end
            if (merr) begin
               st_q    <= ST_IDLE;
               cnt_q   <= '0;
               irq_m_q <= 1'b1;
            end
            if (fin) begin
               st_q    <= ST_IDLE;
               cnt_q   <= '0;
               cur_q   <= ~cur_q;
               irq_a_q <= ~cur_q;
               irq_b_q <= cur_q;
               tc_q    <= last_i;
            end
         end
      end
   end

   assign cur_o           = cur_q;
   assign fin_o           = fin && !chan_rst_i;
   assign merr_o          = merr && !chan_rst_i;
   assign busy_o          = en_i && (st_q != ST_IDLE);
   assign cnt_o           = cnt_q;
   assign mem_req_o       = en_i && ((st_q == ST_MRD) || (st_q == ST_MWR));
   assign mem_we_o        = (st_q == ST_MWR);
   assign mem_addr_o      = addr_q;
   assign mem_wdata_o     = byte_q;
   assign dev_out_valid_o = en_i && (st_q == ST_DWR);
   assign dev_out_data_o  = byte_q;
   assign dev_in_ready_o  = en_i && (st_q == ST_DRD);
   assign tc_o            = tc_q;
   assign irq_a_o         = irq_a_q;
   assign irq_b_o         = irq_b_q;
   assign irq_m_o         = irq_m_q;

   // R6: each finish interrupt lasts one cycle, and slots never finish together
   p_irq_a_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a_q |=> !irq_a_q);
   p_irq_b_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b_q |=> !irq_b_q);
   p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_a_q && irq_b_q));
   // R7: terminal count only alongside a slot finish
   p_tc_with_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q |-> (irq_a_q || irq_b_q));
   // R5: frozen channel holds its remaining count
   p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !chan_rst_i) |=> $stable(cnt_q));
   // R2: addresses stay inside the page the buffer started in
   p_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (addr_q[ADDR_W-1:PAGE_LSB] == page_q));
endmodule

// File: rtl/bidir_byte_dma.sv
module bidir_byte_dma
   import bbd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [63:0]       reg_wdata,
   output logic [4:0]        ctrl_q,
   output logic [LEN_W+1:0]  diag_q,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_gnt,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_err,
   output logic              dev_out_valid,
   output logic [7:0]        dev_out_data,
   input  logic              dev_out_ready,
   input  logic              dev_in_valid,
   input  logic [7:0]        dev_in_data,
   output logic              dev_in_ready,
   output logic              dev_tc,
   output logic              irq_ctx_a,
   output logic              irq_ctx_b,
   output logic              irq_mem_err
);
   localparam int NSLOT = 2;

   if (ADDR_W <= PAGE_LSB || ADDR_W > LEN_LSB) begin : g_bad_addr_w
      $error("ADDR_W must lie in %0d..%0d", PAGE_LSB + 1, LEN_LSB);
   end
   if (LEN_W < 1 || LEN_W > LEN_FIELD_W) begin : g_bad_len_w
      $error("LEN_W must lie in 1..%0d", LEN_FIELD_W);
   end

   logic dir_q, en_q;
   logic ctrl_wr, chan_rst;
   logic cur, fin, merr, busy;
   logic [LEN_W-1:0] cnt;
   logic wdata_unused;

   logic [ADDR_W-1:0] s_base  [NSLOT];
   logic [LEN_W-1:0]  s_len   [NSLOT];
   logic              s_last  [NSLOT];
   logic              s_valid [NSLOT];

   assign wdata_unused = ^reg_wdata;
   assign ctrl_wr  = reg_we && (reg_sel == SEL_CTRL);
   assign chan_rst = ctrl_wr && reg_wdata[CB_RST];

   always_ff @(posedge clk) begin
      if (!rst_n || chan_rst) begin
         dir_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            dir_q <= reg_wdata[CB_DIR];
            en_q  <= reg_wdata[CB_EN];
         end
         if (merr) en_q <= 1'b0;
      end
   end

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      localparam int ARM_BIT = (k == 0) ? CB_VA : CB_VB;
      bbd_desc_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (reg_we && (reg_sel == 2'(k))),
         .wbase_i (reg_wdata[ADDR_W-1:0]),
         .wlen_i  (reg_wdata[LEN_LSB +: LEN_W]),
         .wlast_i (reg_wdata[LAST_BIT]),
         .set_i   (ctrl_wr && !chan_rst && reg_wdata[ARM_BIT]),
         .clr_i   (chan_rst || (fin && (cur == 1'(k)))),
         .lock_i  (cur == 1'(k)),
         .base_o  (s_base[k]),
         .len_o   (s_len[k]),
         .last_o  (s_last[k]),
         .valid_o (s_valid[k])
      );
   end

   bbd_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_engine (
      .clk             (clk),
      .rst_n           (rst_n),
      .chan_rst_i      (chan_rst),
      .en_i            (en_q),
      .dir_i           (dir_q),
      .valid_i         (s_valid[cur]),
      .base_i          (s_base[cur]),
      .len_i           (s_len[cur]),
      .last_i          (s_last[cur]),
      .cur_o           (cur),
      .fin_o           (fin),
      .merr_o          (merr),
      .busy_o          (busy),
      .cnt_o           (cnt),
      .mem_req_o       (mem_req),
      .mem_we_o        (mem_we),
      .mem_addr_o      (mem_addr),
      .mem_wdata_o     (mem_wdata),
      .mem_gnt_i       (mem_gnt),
      .mem_rdata_i     (mem_rdata),
      .mem_err_i       (mem_err),
      .dev_out_valid_o (dev_out_valid),
      .dev_out_data_o  (dev_out_data),
      .dev_out_ready_i (dev_out_ready),
      .dev_in_valid_i  (dev_in_valid),
      .dev_in_data_i   (dev_in_data),
      .dev_in_ready_o  (dev_in_ready),
      .tc_o            (dev_tc),
      .irq_a_o         (irq_ctx_a),
      .irq_b_o         (irq_ctx_b),
      .irq_m_o         (irq_mem_err)
   );

   assign ctrl_q = {s_valid[0], s_valid[1], 1'b0, en_q, dir_q};
   assign diag_q = {cnt, busy, cur};

   // R9: a memory error interrupt is always accompanied by a cleared enable
   p_merr_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mem_err |-> !en_q);
   // R9: no request in the cycle after the error interrupt
   p_merr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mem_err |-> !mem_req);
endmodule

// File: tb/test_bidir_byte_dma.sv
`timescale 1ns/1ps
module test_bidir_byte_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [63:0] reg_wdata = '0;
   logic [4:0]  ctrl_q;
   logic [13:0] diag_q;
   logic        mem_req, mem_we, mem_gnt, mem_err;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready;
   logic [7:0]  dev_out_data, dev_in_data;
   logic        dev_tc, irq_ctx_a, irq_ctx_b, irq_mem_err;

   logic        ready_on = 1'b1;
   logic        err_on = 1'b0;
   logic [31:0] err_addr = '0;
   logic [7:0]  mem [8192];
   logic [7:0]  cap [512];
   logic [7:0]  in_seq = 8'h21;
   int ncap = 0, cnt_a = 0, cnt_b = 0, cnt_m = 0, cnt_tc = 0, nreq = 0;
   int total = 0, fails = 0;

   always #2.5 clk = ~clk;

   bidir_byte_dma i_bidir_byte_dma (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ctrl_q(ctrl_q), .diag_q(diag_q),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
      .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
      .dev_tc(dev_tc), .irq_ctx_a(irq_ctx_a), .irq_ctx_b(irq_ctx_b), .irq_mem_err(irq_mem_err)
   );

   // memory and peripheral models
   assign mem_gnt       = mem_req;
   assign mem_rdata     = mem[mem_addr[12:0]];
   assign mem_err       = err_on && (mem_addr == err_addr);
   assign dev_out_ready = ready_on;
   assign dev_in_valid  = 1'b1;
   assign dev_in_data   = in_seq;

   function automatic logic [7:0] fill(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   initial for (int i = 0; i < 8192; i++) mem[i] = fill(i);

   always @(posedge clk) begin
      if (mem_req && mem_gnt && mem_we && !mem_err) mem[mem_addr[12:0]] <= mem_wdata;
      if (dev_out_valid && dev_out_ready) begin cap[ncap % 512] <= dev_out_data; ncap <= ncap + 1; end
      if (dev_in_valid && dev_in_ready) in_seq <= in_seq + 8'd13;
      if (irq_ctx_a) cnt_a <= cnt_a + 1;
      if (irq_ctx_b) cnt_b <= cnt_b + 1;
      if (irq_mem_err) cnt_m <= cnt_m + 1;
      if (dev_tc) cnt_tc <= cnt_tc + 1;
      if (mem_req) nreq <= nreq + 1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   task automatic wr(input logic [1:0] s, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [63:0] desc(input logic last, input logic [11:0] len, input logic [31:0] base);
      return {last, 19'd0, len, base};
   endfunction

   task automatic wait_irq(input bit is_b, input int tgt);
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if ((is_b ? cnt_b : cnt_a) >= tgt) return;
      end
      chk(1'b0, "R6 finish timeout", is_b ? cnt_b : cnt_a, tgt);
   endtask

   // check captured peripheral bytes [from, from+len) against memory fill at base
   task automatic chk_out(input string req, input int from, input int len, input int base);
      bit ok = 1'b1;
      int bad_a = 0, bad_e = 0;
      for (int i = 0; i < len; i++)
         if (cap[(from + i) % 512] !== fill(base + i)) begin
            ok = 1'b0; bad_a = int'(cap[(from + i) % 512]); bad_e = int'(fill(base + i));
         end
      chk(ok, req, bad_a, bad_e);
   endtask

   // vectors: [29] dir, [28] last, [27:12] base, [11:0] length
   localparam logic [29:0] VEC [6] = '{
      {1'b0, 1'b1, 16'h0103, 12'd5},
      {1'b1, 1'b0, 16'h0400, 12'd8},
      {1'b0, 1'b0, 16'h0FFA, 12'd6},
      {1'b1, 1'b1, 16'h0840, 12'd1},
      {1'b0, 1'b1, 16'h0200, 12'd0},
      {1'b0, 1'b0, 16'h1300, 12'd3}
   };

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R6 watchdog", 0, 1);
      summary();
   end

   initial begin
      int c0, t0, q0, ia, ib, im;
      logic [7:0] s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(ctrl_q == 5'd0, "R4 reset ctrl", ctrl_q, 0);
      chk(diag_q == 14'd0, "R10 reset diag", diag_q, 0);
      chk(!mem_req && !dev_out_valid && !dev_in_ready && !dev_tc, "R5 reset quiet",
          {mem_req, dev_out_valid, dev_in_ready, dev_tc}, 0);

      // table walk: slots alternate A, B
      for (int v = 0; v < 6; v++) begin
         bit d, l, is_b;
         int b, n;
         d = VEC[v][29]; l = VEC[v][28]; b = int'(VEC[v][27:12]); n = int'(VEC[v][11:0]);
         is_b = v[0];
         c0 = ncap; t0 = cnt_tc; q0 = nreq; s0 = in_seq;
         ia = is_b ? cnt_b : cnt_a;
         wr(is_b ? 2'd1 : 2'd0, desc(l, 12'(n), 32'(b)));
         wr(2'd2, {59'd0, ~is_b, is_b, 1'b0, 1'b1, d});
         wait_irq(is_b, ia + 1);
         repeat (2) @(negedge clk);
         if (!d) begin
            chk(ncap - c0 == n, "R2 out byte count", ncap - c0, n);
            chk_out("R2 R1 out bytes", c0, n, b);
         end else begin
            bit ok = 1'b1;
            for (int i = 0; i < n; i++)
               if (mem[b + i] !== 8'(s0 + 8'(13 * i))) ok = 1'b0;
            chk(ok, "R3 in bytes in memory", mem[b], s0);
         end
         chk(cnt_tc - t0 == int'(l), "R7 terminal count", cnt_tc - t0, l);
         if (n == 0) chk(nreq == q0, "R8 zero length no request", nreq - q0, 0);
         chk(diag_q[13:1] == 13'd0 && diag_q[0] == ~is_b, "R10 idle diag", diag_q, {~is_b});
      end

      // ping-pong: both slots armed at once, A runs first then B
      wr(2'd2, 64'h4);
      c0 = ncap; t0 = cnt_tc; ia = cnt_a; ib = cnt_b;
      wr(2'd0, desc(1'b0, 12'd3, 32'h1400));
      wr(2'd1, desc(1'b1, 12'd2, 32'h1500));
      wr(2'd2, 64'h1A);
      chk(ctrl_q == 5'b11010, "R4 both armed", ctrl_q, 5'b11010);
      wait_irq(1'b1, ib + 1);
      repeat (2) @(negedge clk);
      chk(cnt_a - ia == 1 && cnt_b - ib == 1, "R6 both finished", cnt_a - ia, 1);
      chk_out("R6 A bytes first", c0, 3, 32'h1400);
      chk_out("R6 B bytes second", c0 + 3, 2, 32'h1500);
      chk(cnt_tc - t0 == 1, "R7 tc only for B", cnt_tc - t0, 1);
      chk(ctrl_q[4:3] == 2'b00, "R6 armed bits cleared", ctrl_q[4:3], 0);

      // freeze mid-transfer
      wr(2'd2, 64'h4);
      ready_on = 1'b0;
      c0 = ncap; ia = cnt_a;
      wr(2'd0, desc(1'b0, 12'd4, 32'h1600));
      wr(2'd2, 64'h12);
      repeat (4) @(negedge clk);
      chk(diag_q == 14'h012, "R10 busy diag", diag_q, 14'h012);
      chk(dev_out_valid, "R2 byte offered", dev_out_valid, 1);
      wr(2'd2, 64'h0);
      repeat (2) @(negedge clk);
      chk(diag_q == 14'h010, "R5 frozen diag", diag_q, 14'h010);
      chk(!dev_out_valid && !mem_req, "R5 frozen quiet", {dev_out_valid, mem_req}, 0);
      ready_on = 1'b1;
      repeat (4) @(negedge clk);
      chk(ncap == c0, "R5 no handshake while frozen", ncap - c0, 0);
      wr(2'd2, 64'h2);
      wait_irq(1'b0, ia + 1);
      repeat (2) @(negedge clk);
      chk(ncap - c0 == 4, "R5 resumed count", ncap - c0, 4);
      chk_out("R5 resumed bytes", c0, 4, 32'h1600);

      // write to armed current slot is ignored
      wr(2'd2, 64'h4);
      c0 = ncap; ia = cnt_a;
      wr(2'd0, desc(1'b0, 12'd2, 32'h1700));
      wr(2'd2, 64'h10);
      wr(2'd0, desc(1'b1, 12'd5, 32'h1800));
      wr(2'd2, 64'h2);
      wait_irq(1'b0, ia + 1);
      repeat (2) @(negedge clk);
      chk(ncap - c0 == 2, "R11 original length kept", ncap - c0, 2);
      chk_out("R11 original base kept", c0, 2, 32'h1700);

      // memory error
      wr(2'd2, 64'h4);
      c0 = ncap; ia = cnt_a; im = cnt_m;
      err_addr = 32'h1902; err_on = 1'b1;
      wr(2'd0, desc(1'b0, 12'd5, 32'h1900));
      wr(2'd2, 64'h12);
      for (int k = 0; k < 100 && cnt_m == im; k++) @(negedge clk);
      @(negedge clk);
      chk(cnt_m - im == 1, "R9 error interrupt", cnt_m - im, 1);
      chk(ctrl_q[1] == 1'b0, "R9 enable cleared", ctrl_q[1], 0);
      chk(ncap - c0 == 2 && cnt_a == ia, "R9 stopped", ncap - c0, 2);
      q0 = nreq;
      repeat (10) @(negedge clk);
      chk(nreq == q0, "R9 no further request", nreq - q0, 0);
      err_on = 1'b0;

      // channel reset clears armed slot
      chk(ctrl_q[4] == 1'b1, "R4 slot A still armed", ctrl_q[4], 1);
      wr(2'd2, 64'h4);
      chk(ctrl_q == 5'd0 && diag_q == 14'd0, "R4 channel reset", {ctrl_q, diag_q}, 0);
      summary();
   end
endmodule